// File: doc/BRIEF.md
# IO Bank Freeze/Thaw Sequencer

This block moves a group of IO channels between a frozen state, where pads are held safe, and a thawed state, where they run normally. Several general channels and one high-speed channel each get a set of registered control outputs. The high-speed channel has extra outputs for regulator reset, termination reset, calibration start and DLL reset. A single request with a direction bit starts a full freeze or a full thaw. The block then steps through every channel in a fixed order and inserts minimum gaps between steps.

Short gaps are whole system-clock cycles, rounded up from nanosecond minimums and a clock-period parameter. The two long waits on the high-speed thaw are counted in cycles of a free-running oscillator. That oscillator is brought into the system domain by a synchronizer and an edge detector. Software sees a per-channel frozen flag, a busy flag and a one-cycle done pulse.

Top module: `io_freeze_seq`

## Requirements
- R1: Reset state. After reset every bit of `frozen` is 1, `busy` and `done` are 0, and the outputs hold the frozen pattern. In that pattern every general-channel output is 0. On the high-speed channel `hs_reg_rst`, `hs_term_rst` and `hs_dll_rst` are 1 and all its other outputs are 0.
- R2: Freezing general channel i.
  - `gen_slew_n[i]`, `gen_pull_n[i]` and `gen_tri_n[i]` fall together.
  - `gen_hold_n[i]` and `gen_cfg_done[i]` fall exactly S cycles later.
  - S = ceil(SHORT_GAP_PS / CLK_PERIOD_PS). This is 2 at the defaults.
- R3: Thawing general channel i.
  - `gen_hold_n[i]` and `gen_cfg_done[i]` rise first.
  - `gen_pull_n[i]` and `gen_tri_n[i]` rise S cycles after that.
  - `gen_slew_n[i]` rises S cycles after that.
- R4: Freezing the high-speed channel takes three steps on consecutive cycles.
  - First, slew, pull-up and tristate controls fall.
  - Second, hold and config-done fall while `hs_reg_rst` and `hs_term_rst` rise.
  - Third, `hs_cal_start` falls and `hs_dll_rst` rises.
- R5: Thawing the high-speed channel uses L = ceil(LONG_GAP_PS / CLK_PERIOD_PS) cycles for its short gaps. L is 4 at the defaults.
  - `hs_dll_rst` falls first, and `hs_cal_start` rises L cycles later.
  - Later, pull-up and tristate rise. `hs_reg_rst` falls L cycles after them, and `hs_slew_n` rises L cycles after that.
- R6: On the high-speed thaw, hold and config-done rise and `hs_term_rst` falls CAL_OSC oscillator cycles after `hs_cal_start` rises. Pull-up and tristate rise SETTLE_OSC oscillator cycles after that. Each wait is counted on synchronized oscillator rising edges, so it may differ from the raw edge count by the synchronizer latency.
- R7: Channel order in both directions.
  - General channels are handled in ascending index order, and the high-speed channel comes last.
  - Each channel's first step comes one cycle after the previous channel's last step.
  - The first step comes two cycles after the cycle in which the request is presented.
- R8: A channel's `frozen` bit (index NUM_GEN is the high-speed channel) changes only in the cycle of that channel's final step. When the block is idle, all bits are equal.
- R9: Busy and done.
  - `busy` is high from the cycle after the request through the cycle before the final step.
  - `done` is high for one cycle, in the cycle of the final step, with `busy` low.
- R10: A request presented while `busy` is high is ignored. The running sequence, its timing and the end state are unchanged, and no new sequence starts.
- R11: A request for the state the block already reports gives `done` in the next cycle. `busy` stays low and no output changes.
- R12: Each control output changes at most once per sequence, with no glitches between steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_clk | input | 1 | Free-running oscillator, asynchronous to clk |
| cmd_valid | input | 1 | Request strobe, sampled when idle |
| cmd_freeze | input | 1 | Request direction: 1 freeze, 0 thaw |
| gen_slew_n | output | NUM_GEN | General channel slew enable, active low |
| gen_pull_n | output | NUM_GEN | General channel weak pull-up, active low |
| gen_tri_n | output | NUM_GEN | General channel tristate control, active low |
| gen_hold_n | output | NUM_GEN | General channel bus-hold, active low |
| gen_cfg_done | output | NUM_GEN | General channel config done |
| hs_slew_n | output | 1 | High-speed slew enable, active low |
| hs_pull_n | output | 1 | High-speed weak pull-up, active low |
| hs_tri_n | output | 1 | High-speed tristate control, active low |
| hs_hold_n | output | 1 | High-speed bus-hold, active low |
| hs_cfg_done | output | 1 | High-speed config done |
| hs_reg_rst | output | 1 | High-speed regulator reset |
| hs_term_rst | output | 1 | High-speed termination reset |
| hs_cal_start | output | 1 | High-speed calibration start |
| hs_dll_rst | output | 1 | High-speed DLL reset |
| frozen | output | NUM_GEN+1 | Per-channel frozen status, high-speed channel at the top |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench runs alternating freeze and thaw sequences from the reset state. It records the exact cycle and oscillator count of every output edge. These records tell apart a wrong step order, a wrong gap length and a channel visited out of turn.

Same-direction requests at reset and after each sequence separate the immediate no-op completion from a real run. Opposite-direction requests injected early, midway and late in a run show whether a request made while busy can restart or redirect the sequence. Per-output change counts expose any output that toggles more than once.

// File: rtl/iofrz_pkg.sv
// Shared types for the IO freeze/thaw sequencer.
// Assumes: step codes are only compared, never decoded by position.
package iofrz_pkg;

    // Phases of the step engine
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_WAIT = 2'd2
    } phase_t;

    // One code per step of every channel sequence
    typedef enum logic [3:0] {
        ST_GF_A = 4'd0,   // general freeze: slew/pull/tri low
        ST_GF_B = 4'd1,   // general freeze: hold/cfg low
        ST_GT_A = 4'd2,   // general thaw: hold/cfg high
        ST_GT_B = 4'd3,   // general thaw: pull/tri high
        ST_GT_C = 4'd4,   // general thaw: slew high
        ST_HF_A = 4'd5,   // hs freeze: slew/pull/tri low
        ST_HF_B = 4'd6,   // hs freeze: hold/cfg low, resets high
        ST_HF_C = 4'd7,   // hs freeze: cal low, dll reset high
        ST_HT_A = 4'd8,   // hs thaw: dll reset low
        ST_HT_B = 4'd9,   // hs thaw: cal high
        ST_HT_C = 4'd10,  // hs thaw: hold/cfg high, term reset low
        ST_HT_D = 4'd11,  // hs thaw: pull/tri high
        ST_HT_E = 4'd12,  // hs thaw: regulator reset low
        ST_HT_F = 4'd13   // hs thaw: slew high
    } step_t;

    // Integer ceiling division for cycle counts
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/iofrz_osc_tick.sv
// Brings a free-running oscillator into the system clock domain and
// emits a one-cycle tick per oscillator rising edge.
// Assumes: oscillator high and low phases each last longer than one
// system clock period, so no edge is lost.
module iofrz_osc_tick #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_clk,
    output logic osc_tick
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   tick_q;

    // Synchronizer chain, edge memory and registered rising-edge tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
            tick_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], osc_clk};
            prev_q <= sync_q[SYNC_STAGES-1];
            tick_q <= sync_q[SYNC_STAGES-1] & ~prev_q;
        end
    end

    assign osc_tick = tick_q;

    // A rising edge needs a low sample in between, so ticks never repeat
    assert_tick_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q |=> !tick_q);

endmodule

// File: rtl/iofrz_wait_timer.sv
// Down-counter shared by every wait of the sequencer. It counts either
// system clocks or oscillator ticks and flags the last counted event.
// Assumes: a load value of at least 1; a new load restarts the count.
module iofrz_wait_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             load_osc,
    input  logic             osc_tick,
    output logic             expire
);
    logic             running_q;
    logic             use_osc_q;
    logic [CNT_W-1:0] cnt_q;
    logic             step_en;

    // One count event per clock, or per tick in oscillator mode
    always_comb step_en = running_q && (!use_osc_q || osc_tick);

    // Last counted event of the current wait
    always_comb expire = step_en && (cnt_q == CNT_W'(1));

    // Load, count down and stop at the final event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            use_osc_q <= 1'b0;
            cnt_q     <= '0;
        end else if (load) begin
            running_q <= 1'b1;
            use_osc_q <= load_osc;
            cnt_q     <= load_val;
        end else if (step_en) begin
            cnt_q <= cnt_q - CNT_W'(1);
            if (cnt_q == CNT_W'(1))
                running_q <= 1'b0;
        end
    end

    assert_load_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0));

    assert_idle_after_expire_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !load) |=> !running_q);

endmodule

// File: rtl/iofrz_step_engine.sv
// Walks the freeze or thaw program: general channels in ascending order,
// then the high-speed channel. It owns every control output register and
// the per-channel status.
// Assumes: NUM_GEN >= 1; the timer expires only after a load issued here.
module iofrz_step_engine
    import iofrz_pkg::*;
#(
    parameter int NUM_GEN    = 3,
    parameter int CNT_W      = 10,
    parameter int SHORT_CYC  = 2,
    parameter int LONG_CYC   = 4,
    parameter int CAL_OSC    = 1000,
    parameter int SETTLE_OSC = 33
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic               cmd_freeze,
    input  logic               timer_expire,
    output logic               timer_load,
    output logic [CNT_W-1:0]   timer_val,
    output logic               timer_osc,
    output logic [NUM_GEN-1:0] gen_slew_n,
    output logic [NUM_GEN-1:0] gen_pull_n,
    output logic [NUM_GEN-1:0] gen_tri_n,
    output logic [NUM_GEN-1:0] gen_hold_n,
    output logic [NUM_GEN-1:0] gen_cfg_done,
    output logic               hs_slew_n,
    output logic               hs_pull_n,
    output logic               hs_tri_n,
    output logic               hs_hold_n,
    output logic               hs_cfg_done,
    output logic               hs_reg_rst,
    output logic               hs_term_rst,
    output logic               hs_cal_start,
    output logic               hs_dll_rst,
    output logic [NUM_GEN:0]   frozen,
    output logic               busy,
    output logic               done
);
    localparam int CH_W = (NUM_GEN > 1) ? $clog2(NUM_GEN) : 1;
    localparam logic [CNT_W-1:0] SHORT_LOAD  = (SHORT_CYC > 1) ? CNT_W'(SHORT_CYC - 1) : '0;
    localparam logic [CNT_W-1:0] LONG_LOAD   = (LONG_CYC > 1)  ? CNT_W'(LONG_CYC - 1)  : '0;
    localparam logic [CNT_W-1:0] CAL_LOAD    = CNT_W'(CAL_OSC);
    localparam logic [CNT_W-1:0] SETTLE_LOAD = CNT_W'(SETTLE_OSC);

    phase_t            phase_q;
    step_t             step_q;
    step_t             nxt_step;
    logic [CH_W-1:0]   ch_q;
    logic [CH_W-1:0]   nxt_ch;
    logic              ch_last;
    logic              last;
    logic              apply;
    logic [CNT_W-1:0]  wait_val;
    logic              wait_osc;
    logic              busy_q;
    logic              done_q;
    logic [NUM_GEN:0]  frozen_q;
    logic              all_frozen;
    logic              all_thawed;

    always_comb ch_last    = (ch_q == CH_W'(NUM_GEN - 1));
    always_comb apply      = (phase_q == PH_RUN);
    always_comb all_frozen = &frozen_q;
    always_comb all_thawed = ~|frozen_q;

    // Program table: the wait after the current step and the step that follows
    always_comb begin
        wait_val = '0;
        wait_osc = 1'b0;
        nxt_step = step_q;
        nxt_ch   = ch_q;
        last     = 1'b0;
        case (step_q)
            ST_GF_A: begin wait_val = SHORT_LOAD; nxt_step = ST_GF_B; end
            ST_GF_B: begin
                if (ch_last) begin nxt_step = ST_HF_A; nxt_ch = '0; end
                else begin nxt_step = ST_GF_A; nxt_ch = ch_q + 1'b1; end
            end
            ST_GT_A: begin wait_val = SHORT_LOAD; nxt_step = ST_GT_B; end
            ST_GT_B: begin wait_val = SHORT_LOAD; nxt_step = ST_GT_C; end
            ST_GT_C: begin
                if (ch_last) begin nxt_step = ST_HT_A; nxt_ch = '0; end
                else begin nxt_step = ST_GT_A; nxt_ch = ch_q + 1'b1; end
            end
            ST_HF_A: nxt_step = ST_HF_B;
            ST_HF_B: nxt_step = ST_HF_C;
            ST_HF_C: last = 1'b1;
            ST_HT_A: begin wait_val = LONG_LOAD; nxt_step = ST_HT_B; end
            ST_HT_B: begin wait_val = CAL_LOAD; wait_osc = 1'b1; nxt_step = ST_HT_C; end
            ST_HT_C: begin wait_val = SETTLE_LOAD; wait_osc = 1'b1; nxt_step = ST_HT_D; end
            ST_HT_D: begin wait_val = LONG_LOAD; nxt_step = ST_HT_E; end
            ST_HT_E: begin wait_val = LONG_LOAD; nxt_step = ST_HT_F; end
            ST_HT_F: last = 1'b1;
            default: last = 1'b1;
        endcase
    end

    // Timer load request issued in the same cycle a step is applied
    always_comb begin
        timer_load = apply && !last && (wait_val != '0);
        timer_val  = wait_val;
        timer_osc  = wait_osc;
    end

    // Phase, step pointer, busy and done control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            step_q  <= ST_GF_A;
            ch_q    <= '0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (cmd_valid) begin
                        if (cmd_freeze ? all_frozen : all_thawed) begin
                            done_q <= 1'b1;
                        end else begin
                            phase_q <= PH_RUN;
                            busy_q  <= 1'b1;
                            step_q  <= cmd_freeze ? ST_GF_A : ST_GT_A;
                            ch_q    <= '0;
                        end
                    end
                end
                PH_RUN: begin
                    if (last) begin
                        phase_q <= PH_IDLE;
                        busy_q  <= 1'b0;
                        done_q  <= 1'b1;
                    end else begin
                        step_q <= nxt_step;
                        ch_q   <= nxt_ch;
                        if (wait_val != '0)
                            phase_q <= PH_WAIT;
                    end
                end
                PH_WAIT: begin
                    if (timer_expire)
                        phase_q <= PH_RUN;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // One output register bank and status bit per general channel
    for (genvar i = 0; i < NUM_GEN; i++) begin : g_gen_ch
        logic hit;
        always_comb hit = apply && (ch_q == CH_W'(i));

        // Apply this channel's step to its controls and status
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                gen_slew_n[i]   <= 1'b0;
                gen_pull_n[i]   <= 1'b0;
                gen_tri_n[i]    <= 1'b0;
                gen_hold_n[i]   <= 1'b0;
                gen_cfg_done[i] <= 1'b0;
                frozen_q[i]     <= 1'b1;
            end else if (hit) begin
                case (step_q)
                    ST_GF_A: begin
                        gen_slew_n[i] <= 1'b0;
                        gen_pull_n[i] <= 1'b0;
                        gen_tri_n[i]  <= 1'b0;
                    end
                    ST_GF_B: begin
                        gen_hold_n[i]   <= 1'b0;
                        gen_cfg_done[i] <= 1'b0;
                        frozen_q[i]     <= 1'b1;
                    end
                    ST_GT_A: begin
                        gen_hold_n[i]   <= 1'b1;
                        gen_cfg_done[i] <= 1'b1;
                    end
                    ST_GT_B: begin
                        gen_pull_n[i] <= 1'b1;
                        gen_tri_n[i]  <= 1'b1;
                    end
                    ST_GT_C: begin
                        gen_slew_n[i] <= 1'b1;
                        frozen_q[i]   <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end

        assert_gen_freeze_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(gen_hold_n[i]) |-> (!gen_slew_n[i] && !gen_tri_n[i] && !gen_pull_n[i]));

        assert_gen_thaw_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gen_slew_n[i]) |-> (gen_pull_n[i] && gen_hold_n[i] && gen_cfg_done[i]));
    end

    // High-speed channel controls and status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_slew_n    <= 1'b0;
            hs_pull_n    <= 1'b0;
            hs_tri_n     <= 1'b0;
            hs_hold_n    <= 1'b0;
            hs_cfg_done  <= 1'b0;
            hs_reg_rst   <= 1'b1;
            hs_term_rst  <= 1'b1;
            hs_cal_start <= 1'b0;
            hs_dll_rst   <= 1'b1;
            frozen_q[NUM_GEN] <= 1'b1;
        end else if (apply) begin
            case (step_q)
                ST_HF_A: begin
                    hs_slew_n <= 1'b0;
                    hs_pull_n <= 1'b0;
                    hs_tri_n  <= 1'b0;
                end
                ST_HF_B: begin
                    hs_hold_n   <= 1'b0;
                    hs_cfg_done <= 1'b0;
                    hs_reg_rst  <= 1'b1;
                    hs_term_rst <= 1'b1;
                end
                ST_HF_C: begin
                    hs_cal_start      <= 1'b0;
                    hs_dll_rst        <= 1'b1;
                    frozen_q[NUM_GEN] <= 1'b1;
                end
                ST_HT_A: hs_dll_rst <= 1'b0;
                ST_HT_B: hs_cal_start <= 1'b1;
                ST_HT_C: begin
                    hs_hold_n   <= 1'b1;
                    hs_cfg_done <= 1'b1;
                    hs_term_rst <= 1'b0;
                end
                ST_HT_D: begin
                    hs_pull_n <= 1'b1;
                    hs_tri_n  <= 1'b1;
                end
                ST_HT_E: hs_reg_rst <= 1'b0;
                ST_HT_F: begin
                    hs_slew_n         <= 1'b1;
                    frozen_q[NUM_GEN] <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign frozen = frozen_q;
    assign busy   = busy_q;
    assign done   = done_q;

    assert_hs_freeze_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hs_hold_n) |-> (hs_term_rst && hs_reg_rst && !hs_tri_n && !hs_slew_n));

    assert_cal_after_dll_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_cal_start) |-> !hs_dll_rst);

    assert_reg_after_pull_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hs_reg_rst) |-> (hs_pull_n && hs_tri_n && hs_hold_n));

    assert_status_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(frozen_q) |-> $past(busy_q));

    assert_status_uniform_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE) |-> (all_frozen || all_thawed));

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy_q);

endmodule

// File: rtl/io_freeze_seq.sv
// Top of the IO freeze/thaw sequencer. It derives cycle counts from the
// clock period and wires the oscillator tick, wait timer and step engine.
// Assumes: osc_clk is free-running and slower than half the system clock.
module io_freeze_seq
    import iofrz_pkg::*;
#(
    parameter int NUM_GEN       = 3,
    parameter int CLK_PERIOD_PS = 10000,
    parameter int SHORT_GAP_PS  = 20000,
    parameter int LONG_GAP_PS   = 40000,
    parameter int CAL_OSC       = 1000,
    parameter int SETTLE_OSC    = 33,
    parameter int SYNC_STAGES   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               osc_clk,
    input  logic               cmd_valid,
    input  logic               cmd_freeze,
    output logic [NUM_GEN-1:0] gen_slew_n,
    output logic [NUM_GEN-1:0] gen_pull_n,
    output logic [NUM_GEN-1:0] gen_tri_n,
    output logic [NUM_GEN-1:0] gen_hold_n,
    output logic [NUM_GEN-1:0] gen_cfg_done,
    output logic               hs_slew_n,
    output logic               hs_pull_n,
    output logic               hs_tri_n,
    output logic               hs_hold_n,
    output logic               hs_cfg_done,
    output logic               hs_reg_rst,
    output logic               hs_term_rst,
    output logic               hs_cal_start,
    output logic               hs_dll_rst,
    output logic [NUM_GEN:0]   frozen,
    output logic               busy,
    output logic               done
);
    localparam int SHORT_CYC = ceil_div(SHORT_GAP_PS, CLK_PERIOD_PS);
    localparam int LONG_CYC  = ceil_div(LONG_GAP_PS, CLK_PERIOD_PS);
    localparam int MAX_CNT   = (CAL_OSC > SETTLE_OSC) ? CAL_OSC : SETTLE_OSC;
    localparam int MAX_ALL   = (MAX_CNT > LONG_CYC) ? ((MAX_CNT > SHORT_CYC) ? MAX_CNT : SHORT_CYC)
                                                    : ((LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC);
    localparam int CNT_W     = $clog2(MAX_ALL + 1);

    logic             osc_tick;
    logic             timer_load;
    logic [CNT_W-1:0] timer_val;
    logic             timer_osc;
    logic             timer_expire;

    iofrz_osc_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_clk  (osc_clk),
        .osc_tick (osc_tick)
    );

    iofrz_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (timer_val),
        .load_osc (timer_osc),
        .osc_tick (osc_tick),
        .expire   (timer_expire)
    );

    iofrz_step_engine #(
        .NUM_GEN    (NUM_GEN),
        .CNT_W      (CNT_W),
        .SHORT_CYC  (SHORT_CYC),
        .LONG_CYC   (LONG_CYC),
        .CAL_OSC    (CAL_OSC),
        .SETTLE_OSC (SETTLE_OSC)
    ) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_freeze   (cmd_freeze),
        .timer_expire (timer_expire),
        .timer_load   (timer_load),
        .timer_val    (timer_val),
        .timer_osc    (timer_osc),
        .gen_slew_n   (gen_slew_n),
        .gen_pull_n   (gen_pull_n),
        .gen_tri_n    (gen_tri_n),
        .gen_hold_n   (gen_hold_n),
        .gen_cfg_done (gen_cfg_done),
        .hs_slew_n    (hs_slew_n),
        .hs_pull_n    (hs_pull_n),
        .hs_tri_n     (hs_tri_n),
        .hs_hold_n    (hs_hold_n),
        .hs_cfg_done  (hs_cfg_done),
        .hs_reg_rst   (hs_reg_rst),
        .hs_term_rst  (hs_term_rst),
        .hs_cal_start (hs_cal_start),
        .hs_dll_rst   (hs_dll_rst),
        .frozen       (frozen),
        .busy         (busy),
        .done         (done)
    );

endmodule

// File: tb/tb_io_freeze_seq.sv
// Self-checking bench: records the cycle and oscillator count of every
// output edge and compares them with timings computed from the parameters.
module tb_io_freeze_seq;
    localparam int CLK_PERIOD = 10;
    localparam int G     = 3;
    localparam int S     = 2;      // ceil(20000/10000)
    localparam int L     = 4;      // ceil(40000/10000)
    localparam int CALN  = 1000;
    localparam int SETN  = 33;
    localparam int NB    = 5 * G + 9;

    logic clk = 1'b0;
    logic osc = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic cmd_freeze = 1'b0;
    logic [G-1:0] gen_slew_n, gen_pull_n, gen_tri_n, gen_hold_n, gen_cfg_done;
    logic hs_slew_n, hs_pull_n, hs_tri_n, hs_hold_n, hs_cfg_done;
    logic hs_reg_rst, hs_term_rst, hs_cal_start, hs_dll_rst;
    logic [G:0] frozen;
    logic busy, done;

    io_freeze_seq #(.NUM_GEN(G)) dut (
        .clk(clk), .rst_n(rst_n), .osc_clk(osc),
        .cmd_valid(cmd_valid), .cmd_freeze(cmd_freeze),
        .gen_slew_n(gen_slew_n), .gen_pull_n(gen_pull_n), .gen_tri_n(gen_tri_n),
        .gen_hold_n(gen_hold_n), .gen_cfg_done(gen_cfg_done),
        .hs_slew_n(hs_slew_n), .hs_pull_n(hs_pull_n), .hs_tri_n(hs_tri_n),
        .hs_hold_n(hs_hold_n), .hs_cfg_done(hs_cfg_done), .hs_reg_rst(hs_reg_rst),
        .hs_term_rst(hs_term_rst), .hs_cal_start(hs_cal_start), .hs_dll_rst(hs_dll_rst),
        .frozen(frozen), .busy(busy), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always #13 osc = ~osc;

    int cyc = 0;
    int oscn = 0;
    int checks = 0;
    int errors = 0;
    logic [NB-1:0] obs, prev_obs;
    int chg_cyc [NB];
    int chg_osc [NB];
    int chg_cnt [NB];
    int done_cnt, done_cyc, busy_cnt;

    always @(posedge clk) cyc <= cyc + 1;
    always @(posedge osc) oscn <= oscn + 1;

    // Observed outputs packed: gen kind k channel i at k*G+i, hs j at 5*G+j
    always_comb begin
        for (int i = 0; i < G; i++) begin
            obs[0*G+i] = gen_slew_n[i];
            obs[1*G+i] = gen_pull_n[i];
            obs[2*G+i] = gen_tri_n[i];
            obs[3*G+i] = gen_hold_n[i];
            obs[4*G+i] = gen_cfg_done[i];
        end
        obs[5*G+0] = hs_slew_n;   obs[5*G+1] = hs_pull_n;   obs[5*G+2] = hs_tri_n;
        obs[5*G+3] = hs_hold_n;   obs[5*G+4] = hs_cfg_done; obs[5*G+5] = hs_reg_rst;
        obs[5*G+6] = hs_term_rst; obs[5*G+7] = hs_cal_start; obs[5*G+8] = hs_dll_rst;
    end

    // Edge logger, sampled mid-cycle
    always @(negedge clk) begin
        for (int b = 0; b < NB; b++) begin
            if (obs[b] !== prev_obs[b]) begin
                chg_cyc[b] = cyc;
                chg_osc[b] = oscn;
                chg_cnt[b] = chg_cnt[b] + 1;
            end
        end
        prev_obs = obs;
        if (done) begin
            if (done_cnt == 0) done_cyc = cyc;
            done_cnt = done_cnt + 1;
        end
        if (busy) busy_cnt = busy_cnt + 1;
    end

    function automatic int gi(input int k, input int i);
        return k * G + i;
    endfunction

    function automatic int hi(input int j);
        return 5 * G + j;
    endfunction

    // Expected output value for a settled state
    function automatic logic [NB-1:0] pattern(input bit frz);
        logic [NB-1:0] p;
        p = '0;
        for (int b = 0; b < 5 * G; b++) p[b] = !frz;
        for (int j = 0; j < 5; j++) p[hi(j)] = !frz;
        p[hi(5)] = frz;
        p[hi(6)] = frz;
        p[hi(7)] = !frz;
        p[hi(8)] = frz;
        return p;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi_v);
        checks++;
        if (act < lo || act > hi_v) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi_v);
        end
    endtask

    task automatic clear_log();
        for (int b = 0; b < NB; b++) begin
            chg_cyc[b] = -1;
            chg_osc[b] = 0;
            chg_cnt[b] = 0;
        end
        done_cnt = 0;
        done_cyc = -1;
        busy_cnt = 0;
    endtask

    // Present one request, optionally inject the opposite request later
    task automatic run_req(input bit frz, input int inject, output int rq);
        int k;
        @(negedge clk);
        clear_log();
        rq = cyc;
        cmd_valid = 1'b1;
        cmd_freeze = frz;
        @(negedge clk);
        k = 0;
        while (done_cnt == 0 && k < 20000) begin
            if (k == inject) begin
                cmd_valid = 1'b1;
                cmd_freeze = !frz;
            end else begin
                cmd_valid = 1'b0;
            end
            @(negedge clk);
            k++;
        end
        cmd_valid = 1'b0;
        if (done_cnt == 0) chk("R9 done timeout", 0, 1);
        repeat (4) @(negedge clk);
    endtask

    task automatic settled(input bit frz, input string req);
        chk({req, " pattern"}, int'(obs == pattern(frz)), 1);
        chk({req, " status"}, int'(frozen), frz ? (1 << (G + 1)) - 1 : 0);
        chk({req, " idle busy"}, int'(busy), 0);
        chk({req, " single done"}, done_cnt, 1);
    endtask

    task automatic check_freeze(input int inject);
        int rq, first, a, ha;
        run_req(1'b1, inject, rq);
        first = rq + 2;
        for (int i = 0; i < G; i++) begin
            a = first + i * (S + 1);
            for (int k = 0; k < 3; k++) chk("R2/R7 freeze first step", chg_cyc[gi(k, i)], a);
            for (int k = 3; k < 5; k++) chk("R2 freeze hold step", chg_cyc[gi(k, i)], a + S);
        end
        ha = first + G * (S + 1);
        for (int j = 0; j < 3; j++) chk("R4 hs step1", chg_cyc[hi(j)], ha);
        for (int j = 3; j < 7; j++) chk("R4 hs step2", chg_cyc[hi(j)], ha + 1);
        for (int j = 7; j < 9; j++) chk("R4 hs step3", chg_cyc[hi(j)], ha + 2);
        for (int b = 0; b < NB; b++) chk("R12 freeze one change", chg_cnt[b], 1);
        chk("R9 freeze done cycle", done_cyc, ha + 2);
        chk("R9 freeze busy span", busy_cnt, ha + 2 - (rq + 1));
        settled(1'b1, "R8/R10 after freeze");
    endtask

    task automatic check_thaw(input int inject);
        int rq, first, a, ha, hc, hd;
        run_req(1'b0, inject, rq);
        first = rq + 2;
        for (int i = 0; i < G; i++) begin
            a = first + i * (2 * S + 1);
            for (int k = 3; k < 5; k++) chk("R3/R7 thaw hold step", chg_cyc[gi(k, i)], a);
            for (int k = 1; k < 3; k++) chk("R3 thaw pull step", chg_cyc[gi(k, i)], a + S);
            chk("R3 thaw slew step", chg_cyc[gi(0, i)], a + 2 * S);
        end
        ha = first + G * (2 * S + 1);
        chk("R5 dll release", chg_cyc[hi(8)], ha);
        chk("R5 cal start", chg_cyc[hi(7)], ha + L);
        hc = chg_cyc[hi(3)];
        chk("R6 cfg with hold", chg_cyc[hi(4)], hc);
        chk("R6 term with hold", chg_cyc[hi(6)], hc);
        chk_rng("R6 cal wait osc", chg_osc[hi(3)] - chg_osc[hi(7)], CALN - 1, CALN + 2);
        hd = chg_cyc[hi(1)];
        chk("R6 tri with pull", chg_cyc[hi(2)], hd);
        chk_rng("R6 settle wait osc", chg_osc[hi(1)] - chg_osc[hi(3)], SETN - 1, SETN + 2);
        chk("R5 reg release", chg_cyc[hi(5)], hd + L);
        chk("R5 hs slew", chg_cyc[hi(0)], hd + 2 * L);
        for (int b = 0; b < NB; b++) chk("R12 thaw one change", chg_cnt[b], 1);
        chk("R9 thaw done cycle", done_cyc, hd + 2 * L);
        chk("R9 thaw busy span", busy_cnt, hd + 2 * L - (rq + 1));
        settled(1'b0, "R8/R10 after thaw");
    endtask

    task automatic check_noop(input bit frz);
        int rq, nchg;
        run_req(frz, -1, rq);
        nchg = 0;
        for (int b = 0; b < NB; b++) nchg += chg_cnt[b];
        chk("R11 no output change", nchg, 0);
        chk("R11 done next cycle", done_cyc, rq + 1);
        chk("R11 busy stays low", busy_cnt, 0);
        settled(frz, "R11 state kept");
    endtask

    initial begin
        clear_log();
        prev_obs = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset pattern", int'(obs == pattern(1'b1)), 1);
        chk("R1 reset status", int'(frozen), (1 << (G + 1)) - 1);
        chk("R1 reset busy", int'(busy), 0);
        chk("R1 reset done", int'(done), 0);
        check_noop(1'b1);
        check_thaw(-1);
        check_noop(1'b0);
        check_freeze(-1);
        check_thaw(0);        // R10 injected at start
        check_freeze(0);
        check_thaw(5);        // R10 injected in general phase
        check_freeze(4);
        check_thaw(100);      // R10 injected during oscillator wait
        check_freeze(10);     // R10 injected near the end
        check_noop(1'b1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule